// File: doc/BRIEF.md
# Program and Character Bank Address Translator

This block turns a CPU address inside the upper 32 KB program window and a picture-unit address inside the 8 KB character space into physical ROM addresses. The program window is cut into four 8 KB slots chosen by CPU address bits [14:13]. The character space is cut into eight 1 KB slots chosen by picture-unit address bits [12:10]. Each slot is filled from a bank number supplied by the bank registers next to this block. A program-mode input decides which program slots follow the two switchable program banks and which stay pinned to the top of the ROM.

The ROM sizes arrive as static base-two logarithms, so every bank number wraps by masking with the ROM size. While the bank registers hold no programmed values, which `cfg_valid` low signals, a default map is used: the program window shows the last 32 KB of ROM and character slot i shows 1 KB bank i. The two translated addresses leave through an optional output register, which is enabled by default.

Top module: `bank_xlate`

## Requirements
- R1: With `cfg_valid`=1 and `prg_mode`=0, program slot 0 (CPU bits [14:13]=0) uses `prg_bank0` and slot 1 uses `prg_bank1`.
- R2: With `cfg_valid`=1 and `prg_mode`=0, slot 2 uses the second-to-last 8 KB bank of the program ROM and slot 3 uses the last one.
- R3: With `cfg_valid`=1 and `prg_mode`=1, slot 1 uses `prg_bank0` and slot 2 uses `prg_bank1`.
- R4: With `cfg_valid`=1 and `prg_mode`=1, slots 0 and 3 both use the last 8 KB bank.
- R5: `prg_rom_addr` equals (bank × 8192 + `cpu_addr[12:0]`) modulo 2^`prg_lg2`, for `prg_lg2` from 13 up to the address width. Larger values leave the address unmasked.
- R6: Character slot i (`ppu_addr[12:10]`=i) uses the bank in `chr_banks[8i+7:8i]`. `chr_rom_addr` equals (bank × 1024 + `ppu_addr[9:0]`) modulo 2^`chr_lg2`, for `chr_lg2` from 10 up.
- R7: With `cfg_valid`=0, `prg_mode` and every bank input are ignored. Program slot s maps to bank (2^`prg_lg2`/8192 − 4 + s) modulo the bank count, which is the last 32 KB. Character slot i maps to 1 KB bank i.
- R8: The outputs are registered. Both addresses appear one clock edge after their inputs, stay unchanged between edges, and read zero while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Bank inputs hold programmed values; 0 selects the default map |
| prg_mode | input | 1 | Program slot arrangement select |
| prg_bank0 | input | 5 | First switchable 8 KB program bank |
| prg_bank1 | input | 5 | Second switchable 8 KB program bank |
| chr_banks | input | 64 | Eight 1 KB character banks, slot i in bits [8i+7:8i] |
| prg_lg2 | input | 5 | log2 of program ROM size in bytes |
| chr_lg2 | input | 5 | log2 of character ROM size in bytes |
| cpu_addr | input | 15 | CPU address offset inside the 0x8000 window |
| ppu_addr | input | 13 | Picture-unit address inside character space |
| prg_rom_addr | output | 18 | Translated program ROM byte address |
| chr_rom_addr | output | 18 | Translated character ROM byte address |

## Verification
Both translated addresses have one register between input and output, so each result is due at the first rising edge after its inputs settle. The bench drives every input on the falling edge and reads both outputs on the following falling edge, half a period after the register loads. One directed check changes an input and reads the output before the next rising edge to show the old value is still held. The reset check reads the outputs while reset is held across several edges.

// File: rtl/bx_pkg.sv
package bx_pkg;
   localparam int PRG_OFS_W  = 13;
   localparam int CHR_OFS_W  = 10;
   localparam int PRG_SLOT_W = 2;
   localparam int CHR_SLOT_W = 3;
   localparam int CHR_SLOTS  = 1 << CHR_SLOT_W;

   typedef enum logic [PRG_SLOT_W-1:0] {
      PSLOT_0 = 2'd0,
      PSLOT_1 = 2'd1,
      PSLOT_2 = 2'd2,
      PSLOT_3 = 2'd3
   } prg_slot_e;
endpackage

// File: rtl/bx_prg_sel.sv
module bx_prg_sel
   import bx_pkg::*;
#(
   parameter int BW = 5
) (
   input  logic                  cfg_valid,
   input  logic                  mode,
   input  logic [BW-1:0]         bank0,
   input  logic [BW-1:0]         bank1,
   input  logic [PRG_SLOT_W-1:0] slot,
   output logic [BW-1:0]         bank
);
   localparam logic [BW-1:0] LAST_BANK   = '1;
   localparam logic [BW-1:0] PENULT_BANK = {{(BW-1){1'b1}}, 1'b0};

   prg_slot_e s;
   logic [BW-1:0] boot_bank;

   assign s = prg_slot_e'(slot);
   // last four banks: all-ones upper bits, slot index in the low two
   assign boot_bank = {{(BW-PRG_SLOT_W){1'b1}}, slot};

   always_comb begin
      bank = LAST_BANK;
      if (!cfg_valid) begin
         bank = boot_bank;
      end else if (!mode) begin
         case (s)
            PSLOT_0: bank = bank0;
            PSLOT_1: bank = bank1;
            PSLOT_2: bank = PENULT_BANK;
            default: bank = LAST_BANK;
         endcase
      end else begin
         case (s)
            PSLOT_1: bank = bank0;
            PSLOT_2: bank = bank1;
            default: bank = LAST_BANK;
         endcase
      end
   end
endmodule

// File: rtl/bx_chr_sel.sv
module bx_chr_sel
   import bx_pkg::*;
#(
   parameter int BW = 8
) (
   input  logic                    cfg_valid,
   input  logic [CHR_SLOTS*BW-1:0] banks,
   input  logic [CHR_SLOT_W-1:0]   slot,
   output logic [BW-1:0]           bank
);
   logic [BW-1:0] bank_arr [CHR_SLOTS];

   for (genvar i = 0; i < CHR_SLOTS; i++) begin : g_unpack
      assign bank_arr[i] = banks[i*BW +: BW];
   end

   assign bank = cfg_valid ? bank_arr[slot] : BW'(slot);
endmodule

// File: rtl/bx_rom_mask.sv
module bx_rom_mask #(
   parameter int AW = 18,
   parameter int LW = 5
) (
   input  logic [AW-1:0] addr_in,
   input  logic [LW-1:0] size_lg2,
   output logic [AW-1:0] addr_out
);
   logic [AW-1:0] keep;

   // shift counts at or beyond AW clear everything, leaving all bits kept
   assign keep     = ~({AW{1'b1}} << size_lg2);
   assign addr_out = addr_in & keep;
endmodule

// File: rtl/bank_xlate.sv
module bank_xlate
   import bx_pkg::*;
#(
   parameter int PRG_BW  = 5,
   parameter int CHR_BW  = 8,
   parameter int LG2_W   = 5,
   parameter bit OUT_REG = 1'b1,
   localparam int PRG_AW = PRG_BW + PRG_OFS_W,
   localparam int CHR_AW = CHR_BW + CHR_OFS_W,
   localparam int CPU_W  = PRG_OFS_W + PRG_SLOT_W,
   localparam int PPU_W  = CHR_OFS_W + CHR_SLOT_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_valid,
   input  logic                        prg_mode,
   input  logic [PRG_BW-1:0]           prg_bank0,
   input  logic [PRG_BW-1:0]           prg_bank1,
   input  logic [CHR_SLOTS*CHR_BW-1:0] chr_banks,
   input  logic [LG2_W-1:0]            prg_lg2,
   input  logic [LG2_W-1:0]            chr_lg2,
   input  logic [CPU_W-1:0]            cpu_addr,
   input  logic [PPU_W-1:0]            ppu_addr,
   output logic [PRG_AW-1:0]           prg_rom_addr,
   output logic [CHR_AW-1:0]           chr_rom_addr
);
   if (PRG_BW < PRG_SLOT_W + 1) begin : g_bad_prg
      $error("PRG_BW must exceed the slot select width");
   end
   if (CHR_BW < CHR_SLOT_W) begin : g_bad_chr
      $error("CHR_BW must hold every character slot index");
   end
   if ((1 << LG2_W) <= PRG_AW || (1 << LG2_W) <= CHR_AW) begin : g_bad_lg2
      $error("LG2_W too narrow for the address widths");
   end

   logic [PRG_BW-1:0] prg_bank;
   logic [CHR_BW-1:0] chr_bank;
   logic [PRG_AW-1:0] prg_next;
   logic [CHR_AW-1:0] chr_next;

   bx_prg_sel #(.BW(PRG_BW)) u_prg_sel (
      .cfg_valid (cfg_valid),
      .mode      (prg_mode),
      .bank0     (prg_bank0),
      .bank1     (prg_bank1),
      .slot      (cpu_addr[CPU_W-1 -: PRG_SLOT_W]),
      .bank      (prg_bank)
   );

   bx_chr_sel #(.BW(CHR_BW)) u_chr_sel (
      .cfg_valid (cfg_valid),
      .banks     (chr_banks),
      .slot      (ppu_addr[PPU_W-1 -: CHR_SLOT_W]),
      .bank      (chr_bank)
   );

   bx_rom_mask #(.AW(PRG_AW), .LW(LG2_W)) u_prg_mask (
      .addr_in  ({prg_bank, cpu_addr[PRG_OFS_W-1:0]}),
      .size_lg2 (prg_lg2),
      .addr_out (prg_next)
   );

   bx_rom_mask #(.AW(CHR_AW), .LW(LG2_W)) u_chr_mask (
      .addr_in  ({chr_bank, ppu_addr[CHR_OFS_W-1:0]}),
      .size_lg2 (chr_lg2),
      .addr_out (chr_next)
   );

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prg_rom_addr <= '0;
            chr_rom_addr <= '0;
         end else begin
            prg_rom_addr <= prg_next;
            chr_rom_addr <= chr_next;
         end
      end
   end else begin : g_comb
      assign prg_rom_addr = prg_next;
      assign chr_rom_addr = chr_next;
   end
endmodule

// File: rtl/bx_checker.sv
module bx_checker #(
   parameter int PRG_AW  = 18,
   parameter int CHR_AW  = 18,
   parameter int LG2_W   = 5,
   parameter int CPU_W   = 15,
   parameter int PPU_W   = 13,
   parameter bit OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_valid,
   input logic [LG2_W-1:0]  prg_lg2,
   input logic [LG2_W-1:0]  chr_lg2,
   input logic [CPU_W-1:0]  cpu_addr,
   input logic [PPU_W-1:0]  ppu_addr,
   input logic [PRG_AW-1:0] prg_rom_addr,
   input logic [CHR_AW-1:0] chr_rom_addr
);
   logic             q_ok, q_valid;
   logic [LG2_W-1:0] q_plg, q_clg;
   logic [CPU_W-1:0] q_cpu;
   logic [PPU_W-1:0] q_ppu;

   if (OUT_REG) begin : g_lag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q_ok <= 1'b0;
         end else begin
            q_ok <= 1'b1;
         end
      end
      always_ff @(posedge clk) begin
         q_valid <= cfg_valid;
         q_plg   <= prg_lg2;
         q_clg   <= chr_lg2;
         q_cpu   <= cpu_addr;
         q_ppu   <= ppu_addr;
      end
   end else begin : g_now
      assign q_ok    = 1'b1;
      assign q_valid = cfg_valid;
      assign q_plg   = prg_lg2;
      assign q_clg   = chr_lg2;
      assign q_cpu   = cpu_addr;
      assign q_ppu   = ppu_addr;
   end

   logic [PRG_AW-1:0] pkeep;
   logic [CHR_AW-1:0] ckeep;
   assign pkeep = ~({PRG_AW{1'b1}} << q_plg);
   assign ckeep = ~({CHR_AW{1'b1}} << q_clg);

   a_r5_prg_within_rom: assert property (@(posedge clk) disable iff (!rst_n)
      q_ok |-> (prg_rom_addr & ~pkeep) == '0);

   a_r5_prg_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (q_ok && q_plg >= LG2_W'(13)) |-> prg_rom_addr[12:0] == q_cpu[12:0]);

   a_r6_chr_within_rom: assert property (@(posedge clk) disable iff (!rst_n)
      q_ok |-> (chr_rom_addr & ~ckeep) == '0);

   a_r6_chr_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (q_ok && q_clg >= LG2_W'(10)) |-> chr_rom_addr[9:0] == q_ppu[9:0]);

   // R2 and R4: the top slot always lands in the last bank
   a_r4_top_slot_last: assert property (@(posedge clk) disable iff (!rst_n)
      (q_ok && q_cpu[CPU_W-1 -: 2] == 2'd3) |->
         prg_rom_addr == ({{(PRG_AW-13){1'b1}}, q_cpu[12:0]} & pkeep));

   a_r7_chr_identity: assert property (@(posedge clk) disable iff (!rst_n)
      (q_ok && !q_valid) |->
         chr_rom_addr == (CHR_AW'(q_ppu) & ckeep));
endmodule

bind bank_xlate bx_checker #(
   .PRG_AW  (PRG_AW),
   .CHR_AW  (CHR_AW),
   .LG2_W   (LG2_W),
   .CPU_W   (CPU_W),
   .PPU_W   (PPU_W),
   .OUT_REG (OUT_REG)
) u_bx_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_valid    (cfg_valid),
   .prg_lg2      (prg_lg2),
   .chr_lg2      (chr_lg2),
   .cpu_addr     (cpu_addr),
   .ppu_addr     (ppu_addr),
   .prg_rom_addr (prg_rom_addr),
   .chr_rom_addr (chr_rom_addr)
);

// File: tb/tb_bank_xlate.sv
module tb_bank_xlate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_valid = 1'b0;
   logic        prg_mode = 1'b0;
   logic [4:0]  prg_bank0 = '0;
   logic [4:0]  prg_bank1 = '0;
   logic [63:0] chr_banks;
   logic [4:0]  prg_lg2 = 5'd18;
   logic [4:0]  chr_lg2 = 5'd18;
   logic [14:0] cpu_addr = '0;
   logic [12:0] ppu_addr = '0;
   logic [17:0] prg_rom_addr;
   logic [17:0] chr_rom_addr;

   int n_checks = 0;
   int n_fails  = 0;

   always #5 clk = ~clk;

   // character bank for slot i: 5, 22, 39, 56, 73, 90, 107, 124
   assign chr_banks = {8'd124, 8'd107, 8'd90, 8'd73, 8'd56, 8'd39, 8'd22, 8'd5};

   bank_xlate dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_valid    (cfg_valid),
      .prg_mode     (prg_mode),
      .prg_bank0    (prg_bank0),
      .prg_bank1    (prg_bank1),
      .chr_banks    (chr_banks),
      .prg_lg2      (prg_lg2),
      .chr_lg2      (chr_lg2),
      .cpu_addr     (cpu_addr),
      .ppu_addr     (ppu_addr),
      .prg_rom_addr (prg_rom_addr),
      .chr_rom_addr (chr_rom_addr)
   );

   typedef struct packed {
      logic        valid;
      logic        mode;
      logic [4:0]  b0;
      logic [4:0]  b1;
      logic [14:0] cpu;
      logic [4:0]  plg;
      logic [12:0] ppu;
      logic [4:0]  clg;
      logic [17:0] eprg;
      logic [17:0] echr;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 1'b0, 5'd3,  5'd7, 15'h0123, 5'd18, 13'h0005, 5'd18, 18'h06123, 18'h01405}, // R1 slot0
      '{1'b1, 1'b0, 5'd3,  5'd7, 15'h2ABC, 5'd18, 13'h07FF, 5'd18, 18'h0EABC, 18'h05BFF}, // R1 slot1
      '{1'b1, 1'b0, 5'd3,  5'd7, 15'h4000, 5'd17, 13'h0800, 5'd15, 18'h1C000, 18'h01C00}, // R2 penult, R6 wrap
      '{1'b1, 1'b0, 5'd3,  5'd7, 15'h7FFF, 5'd16, 13'h1FFF, 5'd18, 18'h0FFFF, 18'h1F3FF}, // R2 last
      '{1'b1, 1'b1, 5'd3,  5'd7, 15'h0010, 5'd18, 13'h0C01, 5'd18, 18'h3E010, 18'h0E001}, // R4 slot0
      '{1'b1, 1'b1, 5'd3,  5'd7, 15'h2010, 5'd18, 13'h1000, 5'd16, 18'h06010, 18'h02400}, // R3 slot1
      '{1'b1, 1'b1, 5'd3,  5'd7, 15'h5555, 5'd18, 13'h1400, 5'd18, 18'h0F555, 18'h16800}, // R3 slot2
      '{1'b1, 1'b1, 5'd3,  5'd7, 15'h6001, 5'd18, 13'h1800, 5'd18, 18'h3E001, 18'h1AC00}, // R4 slot3
      '{1'b1, 1'b0, 5'd20, 5'd9, 15'h0000, 5'd17, 13'h0000, 5'd18, 18'h08000, 18'h01400}, // R5 bank wrap
      '{1'b0, 1'b0, 5'd20, 5'd9, 15'h0000, 5'd17, 13'h1C02, 5'd18, 18'h18000, 18'h01C02}, // R7 default
      '{1'b0, 1'b0, 5'd20, 5'd9, 15'h4444, 5'd18, 13'h0403, 5'd10, 18'h3C444, 18'h00003}, // R7 default
      '{1'b0, 1'b1, 5'd3,  5'd7, 15'h7000, 5'd15, 13'h0000, 5'd18, 18'h07000, 18'h00000}, // R7 mode ignored
      '{1'b1, 1'b1, 5'd31, 5'd0, 15'h3FFF, 5'd18, 13'h1FFF, 5'd13, 18'h3FFFF, 18'h013FF}  // R3 top bank, R6
   };

   task automatic check(input string req, input logic [17:0] got, input logic [17:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      cfg_valid = v.valid;
      prg_mode  = v.mode;
      prg_bank0 = v.b0;
      prg_bank1 = v.b1;
      cpu_addr  = v.cpu;
      prg_lg2   = v.plg;
      ppu_addr  = v.ppu;
      chr_lg2   = v.clg;
   endtask

   initial begin
      #200000;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      // R8: outputs cleared while reset is held
      drive(VEC[0]);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R8 reset prg", prg_rom_addr, 18'h0);
      check("R8 reset chr", chr_rom_addr, 18'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VEC[i]);
         @(negedge clk);
         check($sformatf("R1-set vec%0d prg (R5)", i), prg_rom_addr, VEC[i].eprg);
         check($sformatf("vec%0d chr (R6)", i), chr_rom_addr, VEC[i].echr);
      end

      // R8: a new input is not visible before the next rising edge
      @(negedge clk);
      drive(VEC[1]);
      #1;
      check("R8 hold prg", prg_rom_addr, VEC[NV-1].eprg);
      check("R8 hold chr", chr_rom_addr, VEC[NV-1].echr);
      @(negedge clk);
      check("R8 update prg", prg_rom_addr, VEC[1].eprg);
      check("R8 update chr", chr_rom_addr, VEC[1].echr);

      // R7: bank inputs have no effect while cfg_valid is low
      @(negedge clk);
      cfg_valid = 1'b0; prg_mode = 1'b1; prg_bank0 = 5'd1; prg_bank1 = 5'd2;
      cpu_addr = 15'h2004; prg_lg2 = 5'd18; ppu_addr = 13'h0807; chr_lg2 = 5'd18;
      @(negedge clk);
      check("R7 default slot1 prg", prg_rom_addr, 18'h3A004);
      check("R7 default slot2 chr", chr_rom_addr, 18'h00807);

      // R5: size code beyond the address width leaves the address unmasked
      @(negedge clk);
      cfg_valid = 1'b1; prg_mode = 1'b0; prg_bank0 = 5'd17;
      cpu_addr = 15'h0001; prg_lg2 = 5'd25;
      @(negedge clk);
      check("R5 oversize prg", prg_rom_addr, 18'h22001);

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end
endmodule